// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is one DMA channel. Each time a device asks for it, the channel copies one word from a source address to a destination address. Every transfer has two bus cycles. The fetch cycle reads the word at the source pointer into a holding register. The deposit cycle then writes that word to the destination pointer. Each bus cycle passes through four single-clock states: T1, T2, T3 and T4. The bus is zero-wait: the strobes are held for exactly two clocks, and the data returned on a read must be valid at the end of fetch T3.

A pacing mode is captured every time a transfer starts. In source-paced mode the request line is sampled at deposit T1. The next transfer can then follow deposit T4 with no gap, so back-to-back transfers are 8 clocks apart. In destination-paced mode two bus-free idle states come after deposit T4, and the request is sampled at deposit T3. The idle states give the destination time to withdraw its request, and they let other masters use the bus. Back-to-back transfers are then 10 clocks apart.

After every deposit, each pointer steps according to its own control field, and the transfer count decrements. Software loads the pointers and the count while the channel is idle. An optional terminate-on-count stops the channel when the count runs out.

Top module: `dma_xfer_seq`

## Requirements
- R1: While rst_n is low and in the first cycle after it, ack, bus_rd, bus_wr, bus_rel and done are 0, and bus_addr and bus_wdata are 0.
- R2: When the channel is idle and req is 1 at a clock edge, fetch T1 begins in the next cycle. ack is 1 for exactly one cycle per transfer: at fetch T1 in source-paced mode (cfg_dst_sync=0) and at deposit T1 in destination-paced mode (cfg_dst_sync=1).
- R3: bus_rd is 1 in fetch T2 and T3, with bus_addr equal to the source pointer. bus_wr is 1 in deposit T2 and T3, with bus_addr equal to the destination pointer and bus_wdata equal to the bus_rdata sampled at the end of fetch T3. bus_rd and bus_wr are never 1 together. bus_addr and bus_wdata are 0 when their strobe is low.
- R4: In source-paced mode req is sampled at the end of deposit T1, which is four clocks after ack. If req is 1 there, the next fetch T1 directly follows deposit T4, 8 cycles after the previous fetch T1. If req is 0, the channel goes idle.
- R5: In destination-paced mode two idle cycles follow deposit T4. bus_rel is 1 in exactly those two cycles and no strobe is active in them. req is sampled at the end of deposit T3, two clocks after ack. Back-to-back fetch T1 states are 10 cycles apart.
- R6: After each deposit T4, each pointer steps according to its 2-bit field: 2'b01 adds one, 2'b10 subtracts one, 2'b00 and 2'b11 hold. The source pointer uses cfg_src_step and the destination pointer uses cfg_dst_step.
- R7: The count decrements by one after each deposit T4. When cfg_tc_en is 1 and the count is 1 at the sampling point, that transfer is the last one whatever req shows. done is then 1 for exactly one cycle, the cycle after the final state of that transfer.
- R8: With cfg_tc_en=1 and a count of 0, req does not start a transfer from idle.
- R9: With cfg_tc_en=0, the count does not stop the channel; transfers continue while req is held, and the count wraps.
- R10: ld_en loads ld_src, ld_dst and ld_cnt only while the channel is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dst_sync | input | 1 | 1 = destination-paced, 0 = source-paced |
| cfg_tc_en | input | 1 | Stop when the count runs out |
| cfg_src_step | input | 2 | Source pointer step field |
| cfg_dst_step | input | 2 | Destination pointer step field |
| ld_en | input | 1 | Load pointers and count (idle only) |
| ld_src | input | AW | Source pointer load value |
| ld_dst | input | AW | Destination pointer load value |
| ld_cnt | input | CW | Count load value |
| req | input | 1 | Synchronous transfer request |
| ack | output | 1 | One-cycle acknowledge |
| bus_addr | output | AW | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data |
| bus_rel | output | 1 | Bus released to other masters |
| done | output | 1 | Terminal-count pulse |

## Verification
The hardest case to reach is the edge of the sampling point: req dropping in exactly the cycle before it is sampled, as opposed to one cycle later. In source-paced mode that point is four clocks after ack; in destination-paced mode it is two clocks after ack. Directed cases drop req in each mode at both of these offsets from the observed ack and count the writes that follow. Random req patterns, with the mode, step and count changed at idle boundaries, are compared every cycle against a phase model in the bench.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_F1, ST_F2, ST_F3, ST_F4,
    ST_D1, ST_D2, ST_D3, ST_D4,
    ST_I1, ST_I2
  } seq_state_e;

  typedef enum logic [1:0] {
    STEP_HOLD  = 2'b00,
    STEP_INC   = 2'b01,
    STEP_DEC   = 2'b10,
    STEP_HOLDX = 2'b11
  } step_e;
endpackage

// File: rtl/dma_ptr_reg.sv
module dma_ptr_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         upd,
  input  logic [1:0]   step,
  output logic [W-1:0] ptr
);
  import dma_seq_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (load) begin
      ptr <= load_val;
    end else if (upd) begin
      unique case (step_e'(step))
        STEP_INC: ptr <= ptr + W'(1);
        STEP_DEC: ptr <= ptr - W'(1);
        default:  ptr <= ptr;
      endcase
    end
  end
endmodule

// File: rtl/dma_cnt_reg.sv
module dma_cnt_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         is_zero,
  output logic         is_one
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - W'(1);
  end

  assign is_zero = (cnt_q == '0);
  assign is_one  = (cnt_q == W'(1));
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic dst_sync,
  input  logic tc_en,
  input  logic req,
  input  logic cnt_zero,
  input  logic cnt_one,
  output logic idle,
  output logic ack,
  output logic rd_ph,
  output logic wr_ph,
  output logic cap,
  output logic upd,
  output logic rel,
  output logic done
);
  import dma_seq_pkg::*;

  seq_state_e state, nxt;
  logic mode_q, go_q, term_q, done_q;
  logic smp, last, term_now;

  assign smp      = mode_q ? (state == ST_D3) : (state == ST_D1);
  assign last     = mode_q ? (state == ST_I2) : (state == ST_D4);
  assign term_now = tc_en && cnt_one;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (req && !(tc_en && cnt_zero)) nxt = ST_F1;
      ST_F1:   nxt = ST_F2;
      ST_F2:   nxt = ST_F3;
      ST_F3:   nxt = ST_F4;
      ST_F4:   nxt = ST_D1;
      ST_D1:   nxt = ST_D2;
      ST_D2:   nxt = ST_D3;
      ST_D3:   nxt = ST_D4;
      ST_D4:   nxt = mode_q ? ST_I1 : (go_q ? ST_F1 : ST_IDLE);
      ST_I1:   nxt = ST_I2;
      ST_I2:   nxt = go_q ? ST_F1 : ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      mode_q <= 1'b0;
      go_q   <= 1'b0;
      term_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      state  <= nxt;
      done_q <= last && term_q;
      if (nxt == ST_F1) mode_q <= dst_sync;
      if (smp) begin
        term_q <= term_now;
        go_q   <= req && !term_now;
      end
    end
  end

  assign idle  = (state == ST_IDLE);
  assign ack   = mode_q ? (state == ST_D1) : (state == ST_F1);
  assign rd_ph = (state == ST_F2) || (state == ST_F3);
  assign wr_ph = (state == ST_D2) || (state == ST_D3);
  assign cap   = (state == ST_F3);
  assign upd   = (state == ST_D4);
  assign rel   = (state == ST_I1) || (state == ST_I2);
  assign done  = done_q;
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_dst_sync,
  input  logic          cfg_tc_en,
  input  logic [1:0]    cfg_src_step,
  input  logic [1:0]    cfg_dst_step,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_src,
  input  logic [AW-1:0] ld_dst,
  input  logic [CW-1:0] ld_cnt,
  input  logic          req,
  output logic          ack,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_rel,
  output logic          done
);
  localparam int NPTR = 2;

  logic idle, rd_ph, wr_ph, cap, upd, cnt_zero, cnt_one, load_ok;
  logic [DW-1:0] hold_q;
  logic [AW-1:0] ptr_ld  [NPTR];
  logic [1:0]    ptr_stp [NPTR];
  logic [AW-1:0] ptr_q   [NPTR];

  assign load_ok    = ld_en && idle;
  assign ptr_ld[0]  = ld_src;
  assign ptr_ld[1]  = ld_dst;
  assign ptr_stp[0] = cfg_src_step;
  assign ptr_stp[1] = cfg_dst_step;

  dma_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .dst_sync(cfg_dst_sync), .tc_en(cfg_tc_en),
    .req(req), .cnt_zero(cnt_zero), .cnt_one(cnt_one), .idle(idle),
    .ack(ack), .rd_ph(rd_ph), .wr_ph(wr_ph), .cap(cap), .upd(upd),
    .rel(bus_rel), .done(done)
  );

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    dma_ptr_reg #(.W(AW)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(load_ok), .load_val(ptr_ld[i]),
      .upd(upd), .step(ptr_stp[i]), .ptr(ptr_q[i])
    );
  end

  dma_cnt_reg #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load_ok), .load_val(ld_cnt),
    .dec(upd), .is_zero(cnt_zero), .is_one(cnt_one)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)   hold_q <= '0;
    else if (cap) hold_q <= bus_rdata;
  end

  assign bus_rd    = rd_ph;
  assign bus_wr    = wr_ph;
  assign bus_addr  = rd_ph ? ptr_q[0] : (wr_ph ? ptr_q[1] : '0);
  assign bus_wdata = wr_ph ? hold_q : '0;
endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          bus_rel,
  input logic          done,
  input logic [AW-1:0] bus_addr
);
  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  p_rd_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd) |=> bus_rd);
  p_rd_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && $past(bus_rd)) |-> $stable(bus_addr));
  p_wr_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rd) |=> !bus_wr ##1 bus_wr);
  p_rel_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rel) |=> bus_rel);
  p_rel_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rel |-> (!bus_rd && !bus_wr && !ack));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_rel(bus_rel), .done(done), .bus_addr(bus_addr)
);

// File: tb/dma_xfer_seq_tb.sv
module dma_xfer_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_dst_sync = 0, cfg_tc_en = 0, ld_en = 0, req = 0;
  logic [1:0] cfg_src_step = 2'b01, cfg_dst_step = 2'b01;
  logic [15:0] ld_src = 0, ld_dst = 0, ld_cnt = 0;
  logic ack, bus_rd, bus_wr, bus_rel, done;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;
  int runs = 0, fails = 0;
  int n_wr = 0, n_done = 0, cyc = 0;
  logic prev_wr = 0;
  logic [15:0] last_rd_addr = 0, last_wr_addr = 0;

  always #2 clk = ~clk;

  function automatic logic [15:0] rd_val(input logic [15:0] a);
    return {a[7:0], ~a[15:8]} ^ 16'h5a3c;
  endfunction
  function automatic logic [15:0] stepf(input logic [15:0] p, input logic [1:0] s);
    return (s == 2'b01) ? p + 16'd1 : (s == 2'b10) ? p - 16'd1 : p;
  endfunction

  assign bus_rdata = rd_val(bus_addr);

  dma_xfer_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_dst_sync(cfg_dst_sync), .cfg_tc_en(cfg_tc_en),
    .cfg_src_step(cfg_src_step), .cfg_dst_step(cfg_dst_step), .ld_en(ld_en),
    .ld_src(ld_src), .ld_dst(ld_dst), .ld_cnt(ld_cnt), .req(req), .ack(ack),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rel(bus_rel), .done(done)
  );

  // phase model: 0 idle, 1..4 fetch, 5..8 deposit, 9..10 idle states
  int m_ph = 0;
  logic m_mode = 0, m_go = 0, m_term = 0, m_done = 0;
  logic [15:0] m_src = 0, m_dst = 0, m_cnt = 0;

  always @(posedge clk) begin
    int old;
    logic smp;
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_mode = 0; m_go = 0; m_term = 0; m_done = 0;
      m_src = 0; m_dst = 0; m_cnt = 0;
    end else begin
      old = m_ph;
      m_done = 0;
      smp = m_mode ? (m_ph == 7) : (m_ph == 5);
      if (smp) begin
        m_term = cfg_tc_en && (m_cnt == 16'd1);
        m_go = req && !m_term;
      end
      if (m_ph == 0) begin
        if (req && !(cfg_tc_en && m_cnt == 0)) begin m_ph = 1; m_mode = cfg_dst_sync; end
      end else if (m_ph == 8) begin
        m_src = stepf(m_src, cfg_src_step);
        m_dst = stepf(m_dst, cfg_dst_step);
        m_cnt = m_cnt - 16'd1;
        if (m_mode) m_ph = 9;
        else begin
          m_done = m_term;
          if (m_go) begin m_ph = 1; m_mode = cfg_dst_sync; end else m_ph = 0;
        end
      end else if (m_ph == 10) begin
        m_done = m_term;
        if (m_go) begin m_ph = 1; m_mode = cfg_dst_sync; end else m_ph = 0;
      end else m_ph = m_ph + 1;
      if (ld_en && old == 0) begin m_src = ld_src; m_dst = ld_dst; m_cnt = ld_cnt; end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the phase model, away from the active edge
  always @(negedge clk) begin
    logic e_rd, e_wr;
    if (rst_n) begin
      e_rd = (m_ph == 2 || m_ph == 3);
      e_wr = (m_ph == 6 || m_ph == 7);
      check("R2 ack", ack, m_mode ? (m_ph == 5) : (m_ph == 1));
      check("R3 bus_rd", bus_rd, e_rd);
      check("R3 bus_wr", bus_wr, e_wr);
      check("R6 bus_addr", bus_addr, e_rd ? m_src : (e_wr ? m_dst : 16'h0));
      check("R3 bus_wdata", bus_wdata, e_wr ? rd_val(m_src) : 16'h0);
      check("R5 bus_rel", bus_rel, (m_ph == 9 || m_ph == 10));
      check("R7 done", done, m_done);
      if (bus_wr && !prev_wr) begin n_wr++; last_wr_addr = bus_addr; end
      if (bus_rd) last_rd_addr = bus_addr;
      if (done) n_done++;
    end
    prev_wr = bus_wr;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_idle();
    req = 0;
    for (int i = 0; i < 40 && m_ph != 0; i++) tick(1);
    tick(2);
  endtask

  task automatic do_load(input logic [15:0] s, input logic [15:0] d, input logic [15:0] c);
    ld_src = s; ld_dst = d; ld_cnt = c; ld_en = 1;
    tick(1);
    ld_en = 0;
  endtask

  task automatic wait_ack(output int at);
    at = -1;
    for (int i = 0; i < 40; i++) begin
      tick(1);
      if (ack) begin at = cyc; break; end
    end
  endtask

  // drop req k cycles after ack; return the number of transfers
  task automatic drop_after(input logic mode, input int k, output int nw);
    int a;
    cfg_dst_sync = mode; cfg_tc_en = 0;
    do_load(16'h0100, 16'h0200, 16'd50);
    n_wr = 0;
    req = 1;
    wait_ack(a);
    tick(k);
    req = 0;
    go_idle();
    nw = n_wr;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    int a1, a2, nw;
    void'($urandom(32'h1d5e7));
    tick(3);
    // R1: reset values
    check("R1 ack", ack, 0); check("R1 rd", bus_rd, 0); check("R1 wr", bus_wr, 0);
    check("R1 rel", bus_rel, 0); check("R1 done", done, 0);
    check("R1 addr", bus_addr, 0); check("R1 wdata", bus_wdata, 0);
    rst_n = 1;
    tick(1);
    check("R1 ack after reset", ack, 0);

    // R2/R4: start latency and back-to-back period, source-paced
    cfg_dst_sync = 0;
    do_load(16'h0100, 16'h0200, 16'd20);
    req = 1;
    tick(1);
    check("R2 first state after req", ack, 1);
    a1 = cyc;
    wait_ack(a2);
    check("R4 period", a2 - a1, 8);
    go_idle();

    // R5: period in destination-paced mode
    cfg_dst_sync = 1;
    req = 1;
    wait_ack(a1);
    wait_ack(a2);
    check("R5 period", a2 - a1, 10);
    go_idle();

    // R4: sampling point four clocks after ack
    drop_after(0, 4, nw); check("R4 drop before sample", nw, 1);
    drop_after(0, 5, nw); check("R4 drop after sample", nw, 2);
    // R5: sampling point two clocks after ack
    drop_after(1, 2, nw); check("R5 drop before sample", nw, 1);
    drop_after(1, 3, nw); check("R5 drop after sample", nw, 2);

    // R6: decrementing source, held destination
    cfg_dst_sync = 0; cfg_src_step = 2'b10; cfg_dst_step = 2'b11; cfg_tc_en = 1;
    do_load(16'h0300, 16'h0400, 16'd3);
    n_wr = 0; n_done = 0;
    req = 1; tick(60); go_idle();
    check("R6 last source", last_rd_addr, 16'h02fe);
    check("R6 held dest", last_wr_addr, 16'h0400);
    check("R7 count stop src", n_wr, 3);
    check("R7 done once src", n_done, 1);

    // R7 in destination-paced mode
    cfg_dst_sync = 1; cfg_src_step = 2'b01; cfg_dst_step = 2'b01;
    do_load(16'h0500, 16'h0600, 16'd2);
    n_wr = 0; n_done = 0;
    req = 1; tick(60); go_idle();
    check("R7 count stop dst", n_wr, 2);
    check("R7 done once dst", n_done, 1);

    // R8: zero count blocks start
    do_load(16'h0700, 16'h0800, 16'd0);
    n_wr = 0;
    req = 1; tick(30); go_idle();
    check("R8 zero count ignored", n_wr, 0);

    // R9: no terminate, count wraps
    cfg_tc_en = 0; cfg_dst_sync = 0;
    do_load(16'h0900, 16'h0a00, 16'd1);
    n_wr = 0; n_done = 0;
    req = 1; tick(40); go_idle();
    check("R9 continues past count", n_wr >= 3, 1);
    check("R9 no done", n_done, 0);

    // R10: load while busy is ignored
    cfg_src_step = 2'b00; cfg_dst_step = 2'b00;
    do_load(16'h0b00, 16'h0c00, 16'd9);
    req = 1; tick(3);
    do_load(16'h0d00, 16'h0e00, 16'd9);
    req = 0; go_idle();
    check("R10 busy load ignored", last_rd_addr, 16'h0b00);

    // random phase
    for (int blk = 0; blk < 12; blk++) begin
      go_idle();
      cfg_dst_sync = 1'($urandom);
      cfg_tc_en = 1'($urandom);
      cfg_src_step = 2'($urandom);
      cfg_dst_step = 2'($urandom);
      do_load(16'($urandom), 16'($urandom), 16'($urandom_range(0, 6)));
      for (int i = 0; i < 150; i++) begin
        req = ($urandom_range(0, 3) != 0);
        tick(1);
      end
    end
    go_idle();
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule